// File: doc/BRIEF.md
# Latched parallel-in serial-out register

This block takes a parallel word, holds it in an input capture latch, and sends it out one bit at a time from a shift chain. A rising edge on the capture clock takes a snapshot of all parallel inputs at once into the latch. A mode input decides what the shift chain does. In load mode the chain copies the latch continuously. In shift mode each rising edge of the shift clock moves the chain one stage toward the output and takes the serial input into the first stage. The serial input also lets several blocks be chained end to end.

Capture and serialization are separate steps, so a new snapshot can be taken while the previous word is still shifting out. The serial output is always driven by the last stage. A separate enable output tells a tri-state pad or a shared-bus multiplexer when to drive it; the enable is controlled by an active-low output-enable input. The external capture and shift clocks are slow control signals. They are synchronized into the single system clock domain and edge-detected there.

Top module: `latched_piso`

## Requirements
- R1: The latch loads `par_i` only on a detected rising edge of `cap_clk_i`. Changes on `par_i` at any other time do not reach the latch.
- R2: While `shift_mode_i` is 0 (load mode), the chain follows the latch contents on every system clock, with no shift-clock edge needed.
- R3: If a capture edge is detected in a cycle where `shift_mode_i` is 0, the chain takes the newly captured word in that same cycle, not the old latch contents.
- R4: While `shift_mode_i` is 1, each detected shift-clock rising edge moves the chain one stage toward the output, and `ser_i` enters stage 0. `par_i[0]` maps to stage 0 and `par_i[WIDTH-1]` to the output stage. After a load, WIDTH shifts present bits WIDTH-1 down to 0 at `ser_o`, followed by the `ser_i` bits.
- R5: While `shift_mode_i` is 1 and no shift edge is detected, the chain holds its value. A capture edge in shift mode updates only the latch.
- R6: Shift-clock edges detected while `shift_mode_i` is 0 do not shift the chain.
- R7: `ser_o` equals the last stage of the chain. `ser_oe_o` is 1 when `oe_ni` is 0 and 0 when `oe_ni` is 1. The enable does not change the data on `ser_o`.
- R8: Asserting `rst_ni` low clears the latch and the chain to zero. `ser_oe_o` still follows `oe_ni` during reset.
- R9: With SYNC_STAGES=2, a rise of `cap_clk_i` or `sh_clk_i` that is set up before system clock edge 1 takes effect at edge 3. It is not visible after edge 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| par_i | input | WIDTH | Parallel data word; bit 0 feeds stage 0 |
| cap_clk_i | input | 1 | Capture clock; rising edge loads the latch |
| sh_clk_i | input | 1 | Shift clock; rising edge advances the chain in shift mode |
| shift_mode_i | input | 1 | 1 = shift mode, 0 = load mode |
| ser_i | input | 1 | Serial data into stage 0 |
| oe_ni | input | 1 | Output enable, active low |
| ser_o | output | 1 | Serial data from the last stage |
| ser_oe_o | output | 1 | High when `ser_o` should be driven |

## Verification
The bench builds the block with WIDTH=8 and SYNC_STAGES=2. At this width a full eight-shift drain, with serial bits following the word, takes only a few hundred cycles. The short synchronizer makes the exact edge-to-effect cycle easy to check, so the same-cycle capture-and-load case and the ignored-shift-in-load-mode case can be sampled in the one cycle where a wrong design would differ. Random words, serial bits, modes and enable settings run alongside directed checks of each ordering.

// File: rtl/piso_pkg.sv
package piso_pkg;
  typedef enum logic {
    MODE_LOAD  = 1'b0,
    MODE_SHIFT = 1'b1
  } piso_mode_e;
endpackage

// File: rtl/pl_edge_detect.sv
module pl_edge_detect #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= async_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[i] <= 1'b0;
          else         sync_q[i] <= sync_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/pl_capture_latch.sv
module pl_capture_latch #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] latch_o,
  output logic [WIDTH-1:0] next_o
);
  logic [WIDTH-1:0] latch_q;

  // value the latch holds after this cycle; lets a same-cycle load see it
  assign next_o = cap_i ? data_i : latch_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) latch_q <= '0;
    else         latch_q <= next_o;

  assign latch_o = latch_q;
endmodule

// File: rtl/pl_shift_chain.sv
module pl_shift_chain
  import piso_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  piso_mode_e       mode_i,
  input  logic             step_i,
  input  logic             ser_i,
  input  logic [WIDTH-1:0] load_i,
  output logic [WIDTH-1:0] chain_o
);
  logic [WIDTH-1:0] chain_q;
  logic [WIDTH-1:0] chain_d;

  always_comb begin
    chain_d = chain_q;
    unique case (mode_i)
      MODE_LOAD:  chain_d = load_i;
      MODE_SHIFT: if (step_i) chain_d = {chain_q[WIDTH-2:0], ser_i};
      default:    chain_d = chain_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;

  assign chain_o = chain_q;
endmodule

// File: rtl/pl_out_stage.sv
module pl_out_stage (
  input  logic last_i,
  input  logic oe_ni,
  output logic ser_o,
  output logic ser_oe_o
);
  assign ser_o    = last_i;
  assign ser_oe_o = ~oe_ni;
endmodule

// File: rtl/latched_piso.sv
module latched_piso
  import piso_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] par_i,
  input  logic             cap_clk_i,
  input  logic             sh_clk_i,
  input  logic             shift_mode_i,
  input  logic             ser_i,
  input  logic             oe_ni,
  output logic             ser_o,
  output logic             ser_oe_o
);
  localparam int unsigned LAST = WIDTH - 1;

  logic             cap_rise;
  logic             sh_rise;
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] latch_next;
  logic [WIDTH-1:0] shift_q;
  piso_mode_e       mode;

  assign mode = piso_mode_e'(shift_mode_i);

  pl_edge_detect #(.STAGES(SYNC_STAGES)) u_cap_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(cap_clk_i),
    .rise_o (cap_rise)
  );

  pl_edge_detect #(.STAGES(SYNC_STAGES)) u_sh_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(sh_clk_i),
    .rise_o (sh_rise)
  );

  pl_capture_latch #(.WIDTH(WIDTH)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap_rise),
    .data_i (par_i),
    .latch_o(latch_q),
    .next_o (latch_next)
  );

  pl_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .step_i (sh_rise),
    .ser_i  (ser_i),
    .load_i (latch_next),
    .chain_o(shift_q)
  );

  pl_out_stage u_out (
    .last_i  (shift_q[LAST]),
    .oe_ni   (oe_ni),
    .ser_o   (ser_o),
    .ser_oe_o(ser_oe_o)
  );
endmodule

// File: rtl/pl_piso_chk.sv
module pl_piso_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] par_i,
  input logic             shift_mode_i,
  input logic             ser_i,
  input logic             oe_ni,
  input logic             ser_o,
  input logic             ser_oe_o,
  input logic             cap_rise,
  input logic             sh_rise,
  input logic [WIDTH-1:0] latch_q,
  input logic [WIDTH-1:0] shift_q
);
  // R1
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_rise |=> $stable(latch_q));

  // R1
  latch_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_rise |=> latch_q == $past(par_i));

  // R2
  load_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_mode_i && !cap_rise) |=> shift_q == $past(latch_q));

  // R3
  load_same_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_mode_i && cap_rise) |=> shift_q == $past(par_i));

  // R4
  shift_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_mode_i && sh_rise) |=> shift_q == {$past(shift_q[WIDTH-2:0]), $past(ser_i)});

  // R5
  shift_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_mode_i && !sh_rise) |=> $stable(shift_q));

  // R9
  edge_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_rise |=> !cap_rise);

  // R7
  out_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_o == shift_q[WIDTH-1]);

  // R8
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |=> (!rst_ni || (latch_q == '0 && shift_q == '0) || $past(cap_rise) ||
                 ($past(shift_mode_i) && $past(sh_rise))));

  // R7
  always_comb oe_track_chk: assert (ser_oe_o == !oe_ni || $isunknown(oe_ni));
endmodule

bind latched_piso pl_piso_chk #(.WIDTH(WIDTH)) u_piso_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .par_i       (par_i),
  .shift_mode_i(shift_mode_i),
  .ser_i       (ser_i),
  .oe_ni       (oe_ni),
  .ser_o       (ser_o),
  .ser_oe_o    (ser_oe_o),
  .cap_rise    (cap_rise),
  .sh_rise     (sh_rise),
  .latch_q     (latch_q),
  .shift_q     (shift_q)
);

// File: tb/tb_latched_piso.sv
`timescale 1ns/1ps
module tb_latched_piso;
  localparam int unsigned W = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] par_i = '0;
  logic         cap_clk_i = 1'b0;
  logic         sh_clk_i = 1'b0;
  logic         shift_mode_i = 1'b0;
  logic         ser_i = 1'b0;
  logic         oe_ni = 1'b0;
  logic         ser_o;
  logic         ser_oe_o;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  logic [W-1:0] exp_latch = '0;
  logic [W-1:0] exp_sh = '0;

  always #2.5 clk = ~clk;

  latched_piso #(.WIDTH(W), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .par_i(par_i), .cap_clk_i(cap_clk_i),
    .sh_clk_i(sh_clk_i), .shift_mode_i(shift_mode_i), .ser_i(ser_i),
    .oe_ni(oe_ni), .ser_o(ser_o), .ser_oe_o(ser_oe_o)
  );

  function automatic logic [W-1:0] shift_in(logic [W-1:0] v, logic b);
    return {v[W-2:0], b};
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic cap_pulse();
    @(negedge clk) cap_clk_i = 1'b1;
    repeat (4) @(negedge clk);
    cap_clk_i = 1'b0;
    repeat (3) @(negedge clk);
    exp_latch = par_i;
    if (!shift_mode_i) exp_sh = exp_latch;
  endtask

  task automatic sh_pulse(logic b);
    @(negedge clk) begin sh_clk_i = 1'b1; ser_i = b; end
    repeat (4) @(negedge clk);
    sh_clk_i = 1'b0;
    repeat (3) @(negedge clk);
    if (shift_mode_i) exp_sh = shift_in(exp_sh, b);
  endtask

  task automatic set_mode(logic m);
    @(negedge clk) shift_mode_i = m;
    repeat (2) @(negedge clk);
    if (!m) exp_sh = exp_latch;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] old_w, new_w;
    void'($urandom(32'h5eed_1234));
    // reset state, R8
    repeat (3) @(negedge clk);
    check("R8 reset ser_o", ser_o, 1'b0);
    check("R8 reset oe", ser_oe_o, 1'b1);
    oe_ni = 1'b1; #1;
    check("R8 oe follows in reset", ser_oe_o, 1'b0);
    oe_ni = 1'b0;
    @(negedge clk) rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // capture and load, R1 R2
    par_i = 8'b1010_0110;
    cap_pulse();
    check("R2 load H", ser_o, 1'b1);
    // R4 drain order H..A then serial bits
    set_mode(1'b1);
    for (int i = W - 1; i >= 0; i--) begin
      check("R4 drain order", ser_o, exp_latch[i]);
      sh_pulse(1'b1);
    end
    check("R4 serial follows", ser_o, 1'b1);

    // R5: capture in shift mode leaves chain alone
    exp_sh = 8'hff;
    par_i = 8'h00;
    cap_pulse();
    check("R5 capture in shift mode", ser_o, 1'b1);
    repeat (10) @(negedge clk);
    check("R5 hold without edge", ser_o, 1'b1);
    set_mode(1'b0);
    check("R2 load after mode", ser_o, 1'b0);

    // R1: par_i change without capture edge
    par_i = 8'hff;
    repeat (6) @(negedge clk);
    check("R1 no capture", ser_o, 1'b0);

    // R3 + R9: same-cycle capture and load
    old_w = 8'h00; new_w = 8'h80;
    par_i = new_w;
    @(negedge clk) cap_clk_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R9 not yet after edge2", ser_o, old_w[W-1]);
    @(negedge clk);
    check("R3 same cycle new word", ser_o, new_w[W-1]);
    repeat (2) @(negedge clk);
    cap_clk_i = 1'b0;
    repeat (3) @(negedge clk);
    exp_latch = new_w; exp_sh = new_w;

    // R6: shift edge in load mode, sample in the cycle a shift would show
    @(negedge clk) begin sh_clk_i = 1'b1; ser_i = 1'b1; end
    @(negedge clk); @(negedge clk); @(negedge clk);
    check("R6 no shift in load", ser_o, 1'b1);
    repeat (2) @(negedge clk);
    sh_clk_i = 1'b0;
    repeat (3) @(negedge clk);
    set_mode(1'b1);
    check("R6 still loaded word", ser_o, 1'b1);
    sh_pulse(1'b0);
    check("R6 bit6 next", ser_o, 1'b0);

    // R7 enable does not alter data
    @(negedge clk) oe_ni = 1'b1;
    @(negedge clk);
    check("R7 oe off", ser_oe_o, 1'b0);
    check("R7 data kept", ser_o, exp_sh[W-1]);
    oe_ni = 1'b0;

    // random mix
    for (int it = 0; it < 25; it++) begin
      logic m;
      int   n;
      par_i = W'($urandom);
      m = 1'($urandom);
      set_mode(m);
      cap_pulse();
      check("R1 random capture", ser_o, exp_sh[W-1]);
      set_mode(1'b0);
      check("R2 random load", ser_o, exp_sh[W-1]);
      set_mode(1'b1);
      n = 1 + int'($urandom_range(10));
      for (int k = 0; k < n; k++) begin
        sh_pulse(1'($urandom));
        check("R4 random shift", ser_o, exp_sh[W-1]);
      end
      @(negedge clk) oe_ni = 1'($urandom);
      #1 check("R7 random oe", ser_oe_o, ~oe_ni);
    end

    // R8 reset mid-operation clears latch and chain
    @(negedge clk) rst_ni = 1'b0;
    @(negedge clk);
    check("R8 chain cleared", ser_o, 1'b0);
    rst_ni = 1'b1;
    shift_mode_i = 1'b0;
    exp_latch = '0; exp_sh = '0;
    repeat (3) @(negedge clk);
    check("R8 latch cleared", ser_o, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule